// File: doc/BRIEF.md
# Multiplexed External Bus Cycle Sequencer

This block turns single requests from a small 8-bit processor core into timed external bus cycles, with every edge placed on a whole oscillator clock. There are two kinds of cycle. An instruction fetch pulses the address latch enable (ALE) and then a short active-low program-store strobe. A data read or data write pulses ALE and then a longer active-low read or write strobe. The low address byte and the data byte share one 8-bit bidirectional port. An external transparent latch captures the low address while ALE is high. The high address byte is driven on a second 8-bit port for the whole cycle.

The core raises a request together with a cycle kind, a 16-bit address and a write byte. The sequencer takes the request only when it is idle. It drives the port enables and strobes in a fixed order, samples returned data on the rising edge of the strobe, and gives a one-clock done pulse as the cycle ends. Phase 0 is the first clock after the request is accepted. Every timing below is counted in phases from there.

Top module: `bus_cycle_seq`

## Requirements
- R1: Out of reset, and whenever no cycle is in progress, ale_o is 0, psen_n_o, rd_n_o and wr_n_o are 1, both port enables are 0 and done_o is 0. rdata_o resets to 0.
- R2: ale_o is 1 in phases 0 and 1 of every cycle and 0 in all later phases. No strobe is low while ale_o is 1.
- R3: ah_oe_o is 1 and ah_o carries address bits 15:8 in every phase of a cycle. In phases 1 and 2, ad_oe_o is 1 and ad_o carries address bits 7:0.
- R4: In a fetch, psen_n_o is low in phases 3 to 5 only. rd_n_o and wr_n_o stay high.
- R5: In a read, rd_n_o is low in phases 5 to 10 only. psen_n_o and wr_n_o stay high.
- R6: In a write, wr_n_o is low in phases 5 to 10 only. ad_oe_o is 1 with ad_o equal to the write byte in phases 4 to 11.
- R7: ad_oe_o is 0 in phase 0 of every cycle, and in every phase after 2 of a fetch or a read.
- R8: In a fetch or a read, the value on ad_i at the clock edge that ends the last low-strobe phase (phase 5 for a fetch, phase 10 for a read) is captured. It appears on rdata_o from the done phase onward and is held until the next capture.
- R9: done_o is 1 for exactly one clock: phase 6 for a fetch, phase 11 for a read or write. A request raised while a cycle is in progress is ignored. If a request is present in the clock after done, a new cycle begins in the clock after that.
- R10: kind_i encodes the cycle: 2'b00 and 2'b01 select a fetch, 2'b10 a read, 2'b11 a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Cycle request, taken only while idle |
| kind_i | input | 2 | Cycle kind: 0x/fetch, 10/read, 11/write |
| addr_i | input | 16 | Cycle address |
| wdata_i | input | 8 | Byte to write |
| rdata_o | output | 8 | Byte returned by the last fetch or read |
| done_o | output | 1 | One-clock end-of-cycle pulse |
| ale_o | output | 1 | Address latch enable, active high |
| psen_n_o | output | 1 | Program-store strobe, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| ad_o | output | 8 | Shared low-address/data port, outgoing value |
| ad_oe_o | output | 1 | Drive enable for the shared port |
| ad_i | input | 8 | Shared port, incoming value |
| ah_o | output | 8 | High address byte |
| ah_oe_o | output | 1 | Drive enable for the high address port |

## Verification
The hardest behaviour to reach from the ports is the sampling instant for returned data. A design that samples one clock early or late would still pass if the bus held one value for the whole strobe. The bench therefore acts as the external device and changes ad_i every clock. It presents the intended byte only in the last low-strobe phase and the byte's complement in all other phases, so only a capture on the correct edge returns the intended value. Two further cases need deliberate timing: a request pulsed mid-cycle, which must not start anything, and a request held high across done, which must start the next cycle after exactly one idle clock.

// File: rtl/bus_seq_pkg.sv
`timescale 1ns/1ps
package bus_seq_pkg;

    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 8;
    localparam int HALF_W  = ADDR_W / 2;
    localparam int PHASE_W = 8;

    typedef logic [PHASE_W-1:0] phase_t;

    typedef enum logic [1:0] {
        CYC_FETCH = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2
    } cyc_kind_e;

    typedef struct packed {
        cyc_kind_e         kind;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    // Phase windows of one cycle; all bounds inclusive.
    typedef struct packed {
        phase_t addr_first;
        phase_t addr_last;
        phase_t strb_first;
        phase_t strb_last;
        phase_t drv_first;
        phase_t drv_last;
        phase_t done_at;
    } bus_win_t;

    function automatic cyc_kind_e decode_kind(input logic [1:0] code);
        if (!code[1])     return CYC_FETCH;
        else if (code[0]) return CYC_WRITE;
        else              return CYC_READ;
    endfunction

    function automatic logic in_win(input phase_t ph, input phase_t lo, input phase_t hi);
        return (ph >= lo) && (ph <= hi);
    endfunction

    function automatic bus_win_t make_win(
        input cyc_kind_e k,
        input int ale_clks, input int a_setup, input int a_hold,
        input int f_gap, input int f_clks,
        input int d_gap, input int d_clks,
        input int w_setup, input int w_hold);
        bus_win_t w;
        int s_first;
        int s_len;
        s_first = ale_clks + ((k == CYC_FETCH) ? f_gap : d_gap);
        s_len   = (k == CYC_FETCH) ? f_clks : d_clks;
        w.addr_first = phase_t'(ale_clks - a_setup);
        w.addr_last  = phase_t'(ale_clks + a_hold - 1);
        w.strb_first = phase_t'(s_first);
        w.strb_last  = phase_t'(s_first + s_len - 1);
        w.drv_first  = phase_t'(s_first - w_setup);
        w.drv_last   = phase_t'(s_first + s_len - 1 + w_hold);
        w.done_at    = (k == CYC_WRITE) ? phase_t'(s_first + s_len - 1 + w_hold)
                                        : phase_t'(s_first + s_len);
        return w;
    endfunction

endpackage

// File: rtl/bus_seq_ctrl.sv
`timescale 1ns/1ps
module bus_seq_ctrl
    import bus_seq_pkg::*;
#(
    parameter int ALE_CLKS    = 2,
    parameter int ADDR_SETUP  = 1,
    parameter int ADDR_HOLD   = 1,
    parameter int FETCH_GAP   = 1,
    parameter int FETCH_CLKS  = 3,
    parameter int DATA_GAP    = 3,
    parameter int DATA_CLKS   = 6,
    parameter int WDATA_SETUP = 1,
    parameter int WDATA_HOLD  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic [1:0]        kind_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              active_o,
    output phase_t            phase_o,
    output bus_req_t          cur_o,
    output bus_win_t          win_o,
    output logic              done_o
);

    logic     active_q;
    phase_t   phase_q;
    bus_req_t cur_q;
    logic     last_phase;

    always_comb begin
        win_o = make_win(cur_q.kind, ALE_CLKS, ADDR_SETUP, ADDR_HOLD,
                         FETCH_GAP, FETCH_CLKS, DATA_GAP, DATA_CLKS,
                         WDATA_SETUP, WDATA_HOLD);
    end

    assign last_phase = active_q && (phase_q == win_o.done_at);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q    <= 1'b0;
            phase_q     <= '0;
            cur_q.kind  <= CYC_FETCH;
            cur_q.addr  <= '0;
            cur_q.wdata <= '0;
        end else if (!active_q) begin
            if (req_i) begin
                active_q    <= 1'b1;
                phase_q     <= '0;
                cur_q.kind  <= decode_kind(kind_i);
                cur_q.addr  <= addr_i;
                cur_q.wdata <= wdata_i;
            end
        end else if (last_phase) begin
            active_q <= 1'b0;
            phase_q  <= '0;
        end else begin
            phase_q <= phase_q + phase_t'(1);
        end
    end

    assign active_o = active_q;
    assign phase_o  = phase_q;
    assign cur_o    = cur_q;
    assign done_o   = last_phase;

endmodule

// File: rtl/bus_seq_strobe.sv
`timescale 1ns/1ps
module bus_seq_strobe
    import bus_seq_pkg::*;
#(
    parameter int ALE_CLKS = 2
) (
    input  logic      active_i,
    input  phase_t    phase_i,
    input  cyc_kind_e kind_i,
    input  phase_t    strb_first_i,
    input  phase_t    strb_last_i,
    output logic      ale_o,
    output logic      psen_n_o,
    output logic      rd_n_o,
    output logic      wr_n_o
);

    logic strobe_on;

    assign strobe_on = active_i && in_win(phase_i, strb_first_i, strb_last_i);

    always_comb begin
        ale_o    = active_i && (phase_i < phase_t'(ALE_CLKS));
        psen_n_o = 1'b1;
        rd_n_o   = 1'b1;
        wr_n_o   = 1'b1;
        unique case (kind_i)
            CYC_FETCH: psen_n_o = !strobe_on;
            CYC_READ:  rd_n_o   = !strobe_on;
            CYC_WRITE: wr_n_o   = !strobe_on;
            default:   ;
        endcase
    end

endmodule

// File: rtl/bus_seq_datapath.sv
`timescale 1ns/1ps
module bus_seq_datapath
    import bus_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              active_i,
    input  phase_t            phase_i,
    input  bus_req_t          cur_i,
    input  phase_t            addr_first_i,
    input  phase_t            addr_last_i,
    input  phase_t            drv_first_i,
    input  phase_t            drv_last_i,
    input  phase_t            strb_last_i,
    input  logic [DATA_W-1:0] ad_i,
    output logic [DATA_W-1:0] ad_o,
    output logic              ad_oe_o,
    output logic [HALF_W-1:0] ah_o,
    output logic              ah_oe_o,
    output logic [DATA_W-1:0] rdata_o
);

    logic              addr_phase;
    logic              wdata_phase;
    logic              capture;
    logic [DATA_W-1:0] rdata_q;

    assign addr_phase  = active_i && in_win(phase_i, addr_first_i, addr_last_i);
    assign wdata_phase = active_i && (cur_i.kind == CYC_WRITE)
                         && in_win(phase_i, drv_first_i, drv_last_i);
    assign capture     = active_i && (cur_i.kind != CYC_WRITE)
                         && (phase_i == strb_last_i);

    always_comb begin
        ad_oe_o = addr_phase || wdata_phase;
        if (wdata_phase)
            ad_o = cur_i.wdata;
        else
            ad_o = cur_i.addr[HALF_W-1:0];
    end

    assign ah_oe_o = active_i;
    assign ah_o    = cur_i.addr[ADDR_W-1:HALF_W];

    always_ff @(posedge clk) begin
        if (rst)
            rdata_q <= '0;
        else if (capture)
            rdata_q <= ad_i;
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/bus_cycle_seq.sv
`timescale 1ns/1ps
module bus_cycle_seq
    import bus_seq_pkg::*;
#(
    parameter int ALE_CLKS    = 2,
    parameter int ADDR_SETUP  = 1,
    parameter int ADDR_HOLD   = 1,
    parameter int FETCH_GAP   = 1,
    parameter int FETCH_CLKS  = 3,
    parameter int DATA_GAP    = 3,
    parameter int DATA_CLKS   = 6,
    parameter int WDATA_SETUP = 1,
    parameter int WDATA_HOLD  = 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_i,
    input  logic [1:0]  kind_i,
    input  logic [15:0] addr_i,
    input  logic [7:0]  wdata_i,
    output logic [7:0]  rdata_o,
    output logic        done_o,
    output logic        ale_o,
    output logic        psen_n_o,
    output logic        rd_n_o,
    output logic        wr_n_o,
    output logic [7:0]  ad_o,
    output logic        ad_oe_o,
    input  logic [7:0]  ad_i,
    output logic [7:0]  ah_o,
    output logic        ah_oe_o
);

    logic     active;
    phase_t   phase;
    bus_req_t cur;
    bus_win_t win;

    bus_seq_ctrl #(
        .ALE_CLKS(ALE_CLKS), .ADDR_SETUP(ADDR_SETUP), .ADDR_HOLD(ADDR_HOLD),
        .FETCH_GAP(FETCH_GAP), .FETCH_CLKS(FETCH_CLKS),
        .DATA_GAP(DATA_GAP), .DATA_CLKS(DATA_CLKS),
        .WDATA_SETUP(WDATA_SETUP), .WDATA_HOLD(WDATA_HOLD)
    ) u_ctrl (
        .clk(clk), .rst(rst), .req_i(req_i), .kind_i(kind_i),
        .addr_i(addr_i), .wdata_i(wdata_i),
        .active_o(active), .phase_o(phase), .cur_o(cur),
        .win_o(win), .done_o(done_o)
    );

    bus_seq_strobe #(.ALE_CLKS(ALE_CLKS)) u_strobe (
        .active_i(active), .phase_i(phase), .kind_i(cur.kind),
        .strb_first_i(win.strb_first), .strb_last_i(win.strb_last),
        .ale_o(ale_o), .psen_n_o(psen_n_o), .rd_n_o(rd_n_o), .wr_n_o(wr_n_o)
    );

    bus_seq_datapath u_data (
        .clk(clk), .rst(rst), .active_i(active), .phase_i(phase), .cur_i(cur),
        .addr_first_i(win.addr_first), .addr_last_i(win.addr_last),
        .drv_first_i(win.drv_first), .drv_last_i(win.drv_last),
        .strb_last_i(win.strb_last), .ad_i(ad_i),
        .ad_o(ad_o), .ad_oe_o(ad_oe_o), .ah_o(ah_o), .ah_oe_o(ah_oe_o),
        .rdata_o(rdata_o)
    );

endmodule

// File: rtl/bus_cycle_seq_chk.sv
`timescale 1ns/1ps
module bus_cycle_seq_chk (
    input logic clk,
    input logic rst,
    input logic done_o,
    input logic ale_o,
    input logic psen_n_o,
    input logic rd_n_o,
    input logic wr_n_o,
    input logic ad_oe_o,
    input logic ah_oe_o
);

    assert_idle_after_done_R1: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (!ale_o && psen_n_o && rd_n_o && wr_n_o));

    assert_ale_quiet_strobes_R2: assert property (@(posedge clk) disable iff (rst)
        ale_o |-> (psen_n_o && rd_n_o && wr_n_o));

    assert_ale_two_clocks_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(ale_o) |=> ale_o);

    assert_ale_not_three_R2: assert property (@(posedge clk) disable iff (rst)
        (ale_o && $past(ale_o)) |=> !ale_o);

    assert_high_port_during_ale_R3: assert property (@(posedge clk) disable iff (rst)
        ale_o |-> ah_oe_o);

    assert_one_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        $countones({!psen_n_o, !rd_n_o, !wr_n_o}) <= 1);

    assert_fetch_after_ale_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(psen_n_o) |-> (!$past(ale_o) && $past(ale_o, 2)));

    assert_write_driven_R6: assert property (@(posedge clk) disable iff (rst)
        !wr_n_o |-> ad_oe_o);

    assert_write_hold_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_n_o) |-> ad_oe_o);

    assert_port_released_R7: assert property (@(posedge clk) disable iff (rst)
        (!psen_n_o || !rd_n_o) |-> !ad_oe_o);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

endmodule

bind bus_cycle_seq bus_cycle_seq_chk u_chk (
    .clk(clk), .rst(rst), .done_o(done_o), .ale_o(ale_o),
    .psen_n_o(psen_n_o), .rd_n_o(rd_n_o), .wr_n_o(wr_n_o),
    .ad_oe_o(ad_oe_o), .ah_oe_o(ah_oe_o)
);

// File: tb/bus_cycle_seq_bench.sv
`timescale 1ns/1ps
module bus_cycle_seq_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        req;
    logic [1:0]  kind;
    logic [15:0] addr;
    logic [7:0]  wdata;
    logic [7:0]  rdata;
    logic        done;
    logic        ale, psen_n, rd_n, wr_n;
    logic [7:0]  ad_o;
    logic        ad_oe;
    logic [7:0]  ad_in;
    logic [7:0]  ah;
    logic        ah_oe;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #2.5 clk = ~clk;

    bus_cycle_seq u_bus_cycle_seq (
        .clk(clk), .rst(rst), .req_i(req), .kind_i(kind), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .done_o(done), .ale_o(ale),
        .psen_n_o(psen_n), .rd_n_o(rd_n), .wr_n_o(wr_n), .ad_o(ad_o),
        .ad_oe_o(ad_oe), .ad_i(ad_in), .ah_o(ah), .ah_oe_o(ah_oe)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests = n_tests + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Expected timing per R2..R9, written from the requirements.
    function automatic int exp_done(input logic [1:0] k);
        return k[1] ? 11 : 6;
    endfunction

    task automatic chk_idle(input string tag);
        chk({tag, " ale"},    16'(ale),    16'd0);
        chk({tag, " psen_n"}, 16'(psen_n), 16'd1);
        chk({tag, " rd_n"},   16'(rd_n),   16'd1);
        chk({tag, " wr_n"},   16'(wr_n),   16'd1);
        chk({tag, " ad_oe"},  16'(ad_oe),  16'd0);
        chk({tag, " ah_oe"},  16'(ah_oe),  16'd0);
        chk({tag, " done"},   16'(done),   16'd0);
    endtask

    // One full cycle. mem is what the external device returns.
    // keep: hold req high throughout (R9 back-to-back case).
    task automatic run_cycle(input logic [1:0] k, input logic [15:0] a,
                             input logic [7:0] wd, input logic [7:0] mem,
                             input bit keep);
        logic is_fetch, is_read, is_write;
        int   last;
        int   s_lo, s_hi;
        is_fetch = !k[1];
        is_read  = (k == 2'b10);
        is_write = (k == 2'b11);
        last = exp_done(k);
        s_lo = is_fetch ? 3 : 5;
        s_hi = is_fetch ? 5 : 10;
        @(negedge clk);
        req = 1'b1; kind = k; addr = a; wdata = wd;
        @(negedge clk);
        if (!keep) req = 1'b0;
        for (int ph = 0; ph <= last; ph++) begin
            // device drives the wanted byte only in the final strobe-low phase (R8)
            ad_in = (ph == s_hi) ? mem : ~mem;
            if (!keep) begin
                req  = (ph == 4);      // mid-cycle request must be ignored (R9)
                kind = ~k;
                addr = ~a;
                wdata = ~wd;
            end
            #1;
            chk("R2 ale", 16'(ale), 16'(ph < 2));
            chk("R3 ah_oe", 16'(ah_oe), 16'd1);
            chk("R3 ah", 16'(ah), 16'(a[15:8]));
            chk("R4 psen_n", 16'(psen_n), 16'(!(is_fetch && ph >= s_lo && ph <= s_hi)));
            chk("R5 rd_n", 16'(rd_n), 16'(!(is_read && ph >= s_lo && ph <= s_hi)));
            chk("R6 wr_n", 16'(wr_n), 16'(!(is_write && ph >= s_lo && ph <= s_hi)));
            if (ph == 1 || ph == 2) begin
                chk("R3 ad_oe addr", 16'(ad_oe), 16'd1);
                chk("R3 ad addr", 16'(ad_o), 16'(a[7:0]));
            end else if (is_write && ph >= 4 && ph <= 11) begin
                chk("R6 ad_oe data", 16'(ad_oe), 16'd1);
                chk("R6 ad data", 16'(ad_o), 16'(wd));
            end else begin
                chk("R7 ad released", 16'(ad_oe), 16'd0);
            end
            chk("R9 done", 16'(done), 16'(ph == last));
            if (ph == last && !is_write)
                chk("R8 rdata at done", 16'(rdata), 16'(mem));
            @(negedge clk);
        end
        #1;
        if (keep) begin
            // request present in the clock after done: idle here, new cycle next
            chk_idle("R9 gap idle");
            @(negedge clk);
            req = 1'b0;
            #1;
            chk("R9 back-to-back start ale", 16'(ale), 16'd1);
            chk("R9 back-to-back ah", 16'(ah), 16'(a[15:8]));
            while (!done) @(negedge clk);
            @(negedge clk);
            #1;
        end else begin
            req = 1'b0;
            chk_idle("R1 idle after cycle");
            if (!is_write)
                chk("R8 rdata held", 16'(rdata), 16'(mem));
            @(negedge clk);
            #1;
            chk("R9 ignored request ale", 16'(ale), 16'd0);
        end
    endtask

    initial begin
        logic [7:0] last_rd;
        logic [1:0] rk;
        logic [7:0] rm;
        void'($urandom(32'd20240611));
        rst = 1'b1; req = 1'b0; kind = 2'b00; addr = '0; wdata = '0; ad_in = 8'h5A;
        repeat (3) @(negedge clk);
        #1;
        chk_idle("R1 reset");
        chk("R1 rdata reset", 16'(rdata), 16'd0);
        rst = 1'b0;

        // directed corner cases
        run_cycle(2'b00, 16'h0000, 8'h00, 8'hA5, 1'b0);  // R10 fetch code 00
        run_cycle(2'b01, 16'hFFFF, 8'hFF, 8'h3C, 1'b0);  // R10 fetch code 01
        run_cycle(2'b10, 16'h12C4, 8'h00, 8'h00, 1'b0);  // R5 read zero
        run_cycle(2'b10, 16'h80FE, 8'h00, 8'hFF, 1'b0);  // R5 read ones
        run_cycle(2'b11, 16'hBEEF, 8'h96, 8'h11, 1'b0);  // R6 write
        last_rd = 8'hFF;
        run_cycle(2'b11, 16'h4321, 8'h00, 8'h77, 1'b0);  // write leaves rdata alone
        chk("R8 rdata unchanged by write", 16'(rdata), 16'(last_rd));
        run_cycle(2'b10, 16'h5555, 8'h00, 8'hC3, 1'b1);  // R9 back-to-back

        // random mix
        for (int i = 0; i < 60; i++) begin
            rk = 2'($urandom_range(0, 3));
            rm = 8'($urandom);
            run_cycle(rk, 16'($urandom), 8'($urandom), rm, 1'($urandom_range(0, 1)));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule